// File: doc/BRIEF.md
# Multi-Channel Link Transmit Scheduler

This block drives the transmit half of a reliable point-to-point serial link that uses acknowledgements. Several producer channels each park one packet in a private region of a shared word buffer and post it by giving its start address and length. The scheduler serves ready channels in turn and wraps each packet in a frame: a start word, the payload, a CRC-32 word and an end word. It emits one 32-bit word per clock with a 4-bit mask that marks which bytes are control characters, so an external 8b/10b encoder can follow it directly.

A channel that has sent its packet waits for the far end's verdict. A positive acknowledgement frees the channel. A negative acknowledgement or a timeout makes the channel rewind to the start address it saved and send the same packet again. The scheduler also splices two kinds of short frames into the stream: acknowledgement frames for the opposite direction, and clock-correction frames requested by a free-running interval counter. Both may land inside a data packet, but only at points that a set of fixed placement and priority rules allows.

Top module: `link_tx_sched`

## Requirements
- R1: After reset, and whenever nothing is pending, every output word is the idle word 0xBC50BC50 with control mask 4'b1010.
- R2: A data frame is a start word {0xFB, channel, 16-bit length in words} with mask 4'b1000, then the payload words with mask 0, then a CRC word with mask 0, then the end word 0xFDFDFDFD with mask 4'b1111.
- R3: The CRC word is the CRC-32 (polynomial 0x04C11DB7, seed 0xFFFFFFFF, bits taken MSB first, result inverted) of the payload words only.
- R4: Payload words are read from the channel's buffer region starting at the posted start address, with consecutive addresses that wrap modulo DEPTH (a power of two).
- R5: Ready channels are served in round-robin order, starting from the channel after the one served last; channel 0 comes first after reset.
- R6: A channel that has sent its packet is not sent again until a negative acknowledgement or a timeout arrives. A positive acknowledgement frees it, and a post to a channel that is not free is ignored.
- R7: A negative acknowledgement for a waiting channel makes it resend the same packet from its saved start address with the same length.
- R8: A waiting channel that gets no acknowledgement within TIMEOUT cycles after its end word becomes ready again. Its resend starts on the cycle after that.
- R9: A requested acknowledgement frame is the two words {0x7C, 0x00, info[15:0]} (mask 4'b1000) and 0xFCFCFCFC (mask 4'b1111). It may appear inside a payload but never after the last payload word of a frame, and nothing comes between its two words.
- R10: Every CC_INTERVAL cycles a clock-correction frame of two words 0x1C1C1C1C (mask 4'b1111) becomes pending. It is never placed right after a start word or after the last payload word.
- R11: When clock correction and an acknowledgement are both pending at a point where both are allowed, the clock correction goes out first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_ch | input | CW | Channel of the buffer write |
| wr_addr | input | AW | Word address in the channel region |
| wr_data | input | 32 | Word to store |
| post_valid | input | 1 | Post a packet for a free channel |
| post_ch | input | CW | Posting channel |
| post_start | input | AW | Start address of the packet |
| post_len | input | LW | Payload length in words (8 to DEPTH) |
| ack_in_valid | input | 1 | Far-end verdict arrives |
| ack_in_ch | input | CW | Channel the verdict is for |
| ack_in_nak | input | 1 | 1 = negative, 0 = positive |
| ack_req | input | 1 | Request to send an acknowledgement frame |
| ack_info | input | 16 | Content of that acknowledgement |
| tx_data | output | 32 | Output word, first byte in bits 31:24 |
| tx_k | output | 4 | Control flag per byte, bit 3 for bits 31:24 |

## Verification
Each input is taken at a clock edge and its effect shows in the output word on the next edge. A post to an idle link gives the start word one cycle later. An acknowledgement request latched together with a clock-correction request gives the two correction words, then the two acknowledgement words, on the four edges that follow. A timed-out channel's start word appears TIMEOUT+1 cycles after its end word, or two cycles later if a correction frame takes that slot. The bench samples on the falling edge, so it counts these cycles exactly for the directed priority and timeout cases. For everything else a stream parser rebuilds each frame and checks content, CRC and insertion placement wherever they land.

// File: rtl/link_tx_sched.sv
module link_tx_sched #(
  parameter int NCH         = 3,
  parameter int DEPTH       = 512,
  parameter int CC_INTERVAL = 2048,
  parameter int TIMEOUT     = 4096,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_ch,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          post_valid,
  input  logic [CW-1:0] post_ch,
  input  logic [AW-1:0] post_start,
  input  logic [LW-1:0] post_len,
  input  logic          ack_in_valid,
  input  logic [CW-1:0] ack_in_ch,
  input  logic          ack_in_nak,
  input  logic          ack_req,
  input  logic [15:0]   ack_info,
  output logic [31:0]   tx_data,
  output logic [3:0]    tx_k
);
  localparam int MW = $clog2(NCH * DEPTH);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int IW = $clog2(CC_INTERVAL);
  localparam logic [31:0] W_IDLE = 32'hBC50BC50;
  localparam logic [31:0] W_EOP  = 32'hFDFDFDFD;
  localparam logic [31:0] W_CC   = 32'h1C1C1C1C;
  localparam logic [31:0] W_AEND = 32'hFCFCFCFC;
  localparam logic [1:0] S_FREE = 2'd0, S_READY = 2'd1, S_WAIT = 2'd2;

  typedef enum logic [1:0] {P_IDLE, P_PAY, P_CRC, P_EOP} phase_t;

  logic [31:0]   mem [NCH*DEPTH];
  logic [1:0]    ch_st   [NCH];
  logic [AW-1:0] start_q [NCH];
  logic [LW-1:0] len_q   [NCH];
  logic [TW-1:0] tmr     [NCH];
  phase_t        phase;
  logic [CW-1:0] cur_ch, last_ch, pick;
  logic          pick_ok;
  logic [AW-1:0] rd_ptr;
  logic [LW-1:0] cnt;
  logic [31:0]   crc, rd_word;
  logic [1:0]    ins_kind;
  logic [IW-1:0] cc_cnt;
  logic          cc_pend, ack_pend;
  logic [15:0]   ack_info_q;
  logic          cc_ok, ack_ok;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--)
      r = {r[30:0], 1'b0} ^ ((r[31] ^ d[i]) ? 32'h04C11DB7 : 32'h0);
    return r;
  endfunction

  always_ff @(posedge clk)
    if (wr_en) mem[MW'(int'(wr_ch) * DEPTH + int'(wr_addr))] <= wr_data;

  assign rd_word = mem[MW'(int'(cur_ch) * DEPTH + int'(rd_ptr))];
  assign cc_ok   = (phase == P_IDLE) || (phase == P_PAY && cnt != '0);
  assign ack_ok  = (phase == P_IDLE) || (phase == P_PAY);

  always_comb begin
    pick_ok = 1'b0;
    pick    = last_ch;
    for (int k = NCH; k >= 1; k--) begin
      int idx;
      idx = int'(last_ch) + k;
      if (idx >= NCH) idx = idx - NCH;
      if (ch_st[idx] == S_READY) begin
        pick_ok = 1'b1;
        pick    = CW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        ch_st[i] <= S_FREE; start_q[i] <= '0; len_q[i] <= '0; tmr[i] <= '0;
      end
      phase <= P_IDLE; cur_ch <= '0; last_ch <= CW'(NCH - 1);
      rd_ptr <= '0; cnt <= '0; crc <= '1; ins_kind <= 2'd0;
      cc_cnt <= '0; cc_pend <= 1'b0; ack_pend <= 1'b0; ack_info_q <= '0;
      tx_data <= W_IDLE; tx_k <= 4'b1010;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        logic sending;
        sending = (phase != P_IDLE) && (int'(cur_ch) == i);
        if (ch_st[i] == S_WAIT && !sending) begin
          if (tmr[i] == TW'(TIMEOUT - 1)) begin
            ch_st[i] <= S_READY; tmr[i] <= '0;
          end else tmr[i] <= tmr[i] + 1'b1;
        end
        if (ack_in_valid && int'(ack_in_ch) == i && ch_st[i] == S_WAIT && !sending) begin
          ch_st[i] <= ack_in_nak ? S_READY : S_FREE; tmr[i] <= '0;
        end
        if (post_valid && int'(post_ch) == i && ch_st[i] == S_FREE) begin
          ch_st[i] <= S_READY; start_q[i] <= post_start; len_q[i] <= post_len;
        end
      end

      if (ins_kind == 2'd1) begin
        tx_data <= W_AEND; tx_k <= 4'b1111; ins_kind <= 2'd0;
      end else if (ins_kind == 2'd2) begin
        tx_data <= W_CC; tx_k <= 4'b1111; ins_kind <= 2'd0;
      end else if (cc_pend && cc_ok) begin
        tx_data <= W_CC; tx_k <= 4'b1111; ins_kind <= 2'd2; cc_pend <= 1'b0;
      end else if (ack_pend && ack_ok) begin
        tx_data <= {8'h7C, 8'h00, ack_info_q}; tx_k <= 4'b1000;
        ins_kind <= 2'd1; ack_pend <= 1'b0;
      end else begin
        case (phase)
          P_IDLE:
            if (pick_ok) begin
              tx_data <= {8'hFB, 8'(pick), 16'(len_q[pick])}; tx_k <= 4'b1000;
              cur_ch <= pick; last_ch <= pick; rd_ptr <= start_q[pick];
              cnt <= '0; crc <= '1; phase <= P_PAY;
              ch_st[pick] <= S_WAIT; tmr[pick] <= '0;
            end else begin
              tx_data <= W_IDLE; tx_k <= 4'b1010;
            end
          P_PAY: begin
            tx_data <= rd_word; tx_k <= 4'b0000;
            crc <= crc_step(crc, rd_word);
            rd_ptr <= rd_ptr + 1'b1; cnt <= cnt + 1'b1;
            if (cnt == len_q[cur_ch] - LW'(1)) phase <= P_CRC;
          end
          P_CRC: begin
            tx_data <= ~crc; tx_k <= 4'b0000; phase <= P_EOP;
          end
          default: begin
            tx_data <= W_EOP; tx_k <= 4'b1111; phase <= P_IDLE;
          end
        endcase
      end

      if (cc_cnt == IW'(CC_INTERVAL - 1)) begin
        cc_cnt <= '0; cc_pend <= 1'b1;
      end else cc_cnt <= cc_cnt + 1'b1;
      if (ack_req) begin
        ack_pend <= 1'b1; ack_info_q <= ack_info;
      end
    end
  end

  AST_CC_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_kind == 2'd0 && cc_pend && ack_pend && cc_ok) |=> (tx_k == 4'hF && tx_data == W_CC)); // R11
  AST_CRC_HUGS_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_k == 4'hF && tx_data == W_EOP) |-> $past(tx_k) == 4'h0); // R9
  AST_NO_CC_AFTER_SOP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_k == 4'h8 && tx_data[31:24] == 8'hFB) |=> !(tx_k == 4'hF && tx_data == W_CC)); // R10
  AST_ACK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_k == 4'h8 && tx_data[31:24] == 8'h7C) |=> (tx_k == 4'hF && tx_data == W_AEND)); // R9
  AST_SOP_OWNER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_k == 4'h8 && tx_data[31:24] == 8'hFB) |-> ch_st[cur_ch] == S_WAIT); // R6
endmodule

// File: tb/sim_link_tx_sched.sv
`timescale 1ns/1ps
module sim_link_tx_sched;
  localparam int NCH = 3, DEPTH = 32, CCI = 40, TMO = 300;
  localparam int CW = 2, AW = 5, LW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic wr_en = 0, post_valid = 0, ack_in_valid = 0, ack_in_nak = 0, ack_req = 0;
  logic [CW-1:0] wr_ch = 0, post_ch = 0, ack_in_ch = 0;
  logic [AW-1:0] wr_addr = 0, post_start = 0;
  logic [LW-1:0] post_len = 0;
  logic [31:0] wr_data = 0;
  logic [15:0] ack_info = 0;
  logic [31:0] tx_data;
  logic [3:0]  tx_k;

  link_tx_sched #(.NCH(NCH), .DEPTH(DEPTH), .CC_INTERVAL(CCI), .TIMEOUT(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_addr(wr_addr),
    .wr_data(wr_data), .post_valid(post_valid), .post_ch(post_ch),
    .post_start(post_start), .post_len(post_len), .ack_in_valid(ack_in_valid),
    .ack_in_ch(ack_in_ch), .ack_in_nak(ack_in_nak), .ack_req(ack_req),
    .ack_info(ack_info), .tx_data(tx_data), .tx_k(tx_k));

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] exp_mem [NCH][DEPTH];
  int exp_start [NCH];
  int exp_len [NCH];
  int frame_cnt = 0;
  int frame_ch [512];
  int frame_sop [512];
  int frame_eop [512];
  int mst = 0, m_ch = 0, m_len = 0, m_pcnt = 0, m_bad = 0, ins_exp = 0, sop_cyc = 0;
  int ack_in_frame = 0, acks_seen = 0;
  logic [15:0] last_ack_info = 0;
  logic [31:0] m_crc = 0;
  bit done = 0;

  function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c;
    for (int b = 31; b >= 0; b--) begin
      logic top = r[31] ^ d[b];
      r = r << 1;
      if (top) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      mst = 0; ins_exp = 0;
    end else begin
      cyc++;
      if (ins_exp == 1) begin
        chk(tx_k == 4'hF && tx_data == 32'hFCFCFCFC, "R9 ack second word", tx_data, 32'hFCFCFCFC);
        ins_exp = 0;
      end else if (ins_exp == 2) begin
        chk(tx_k == 4'hF && tx_data == 32'h1C1C1C1C, "R10 cc second word", tx_data, 32'h1C1C1C1C);
        ins_exp = 0;
      end else if (tx_k == 4'hF && tx_data == 32'h1C1C1C1C) begin
        chk(!(mst == 1 && (m_pcnt == 0 || m_pcnt == m_len)) && mst != 2,
            "R10 cc placement", 32'(mst * 1000 + m_pcnt), 0);
        ins_exp = 2;
      end else if (tx_k == 4'h8 && tx_data[31:24] == 8'h7C) begin
        chk(!(mst == 1 && m_pcnt == m_len) && mst != 2,
            "R9 ack placement", 32'(mst * 1000 + m_pcnt), 0);
        ins_exp = 1; acks_seen++; last_ack_info = tx_data[15:0];
        if (mst == 1) ack_in_frame++;
      end else begin
        case (mst)
          0: if (tx_k == 4'h8 && tx_data[31:24] == 8'hFB) begin
               m_ch = int'(tx_data[23:16]);
               if (m_ch >= NCH) m_ch = 0;
               m_len = int'(tx_data[15:0]);
               chk(int'(tx_data[23:16]) < NCH && m_len == exp_len[m_ch], "R2 header length",
                   32'(m_len), 32'(exp_len[m_ch]));
               m_pcnt = 0; m_bad = 0; m_crc = 32'hFFFFFFFF; mst = 1; sop_cyc = cyc;
             end else if (!(tx_k == 4'b1010 && tx_data == 32'hBC50BC50)) begin
               chk(0, "R2 stray word between frames", tx_data, 32'hBC50BC50);
             end
          1: if (m_pcnt < m_len) begin
               if (tx_k != 4'h0 || tx_data != exp_mem[m_ch][(exp_start[m_ch] + m_pcnt) % DEPTH]) m_bad++;
               m_crc = crc_ref(m_crc, tx_data);
               m_pcnt++;
             end else begin
               chk(tx_k == 4'h0 && tx_data == ~m_crc, "R3 crc word", tx_data, ~m_crc);
               chk(m_bad == 0, "R4 payload words", 32'(m_bad), 0);
               mst = 2;
             end
          default: begin
            chk(tx_k == 4'hF && tx_data == 32'hFDFDFDFD, "R2 end word", tx_data, 32'hFDFDFDFD);
            if (frame_cnt < 512) begin
              frame_ch[frame_cnt] = m_ch; frame_sop[frame_cnt] = sop_cyc; frame_eop[frame_cnt] = cyc;
            end
            frame_cnt++;
            mst = 0;
          end
        endcase
      end
    end
  end

  task automatic write_pkt(input int ch, input int st, input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      wr_en = 1; wr_ch = CW'(ch); wr_addr = AW'((st + i) % DEPTH);
      wr_data = 32'(seed) * 32'h9E3779B1 ^ (32'(ch) << 24) ^ (32'(i) * 32'h01000193);
      exp_mem[ch][(st + i) % DEPTH] = wr_data;
    end
    @(negedge clk); wr_en = 0;
  endtask

  task automatic post(input int ch, input int st, input int len, input bit track);
    @(negedge clk);
    post_valid = 1; post_ch = CW'(ch); post_start = AW'(st); post_len = LW'(len);
    if (track) begin exp_start[ch] = st; exp_len[ch] = len; end
    @(negedge clk); post_valid = 0;
  endtask

  task automatic verdict(input int ch, input bit nak);
    @(negedge clk);
    ack_in_valid = 1; ack_in_ch = CW'(ch); ack_in_nak = nak;
    @(negedge clk); ack_in_valid = 0;
  endtask

  task automatic wait_frames(input int n);
    int g = 0;
    while (frame_cnt < n && g < 3000) begin @(negedge clk); g++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int g, base, gap;
    for (int c = 0; c < NCH; c++) begin exp_start[c] = 0; exp_len[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(tx_k == 4'b1010 && tx_data == 32'hBC50BC50, "R1 idle after reset", tx_data, 32'hBC50BC50);
    end

    // R11: line up an ack request with the second clock-correction request
    g = 0;
    while (!(tx_k == 4'hF && tx_data == 32'h1C1C1C1C) && g < 200) begin @(negedge clk); g++; end
    repeat (CCI - 2) @(posedge clk);
    @(negedge clk); ack_req = 1; ack_info = 16'h5A3C;
    @(negedge clk); ack_req = 0;
    @(negedge clk); chk(tx_k == 4'hF && tx_data == 32'h1C1C1C1C, "R11 cc first", tx_data, 32'h1C1C1C1C);
    @(negedge clk); chk(tx_k == 4'hF && tx_data == 32'h1C1C1C1C, "R11 cc second", tx_data, 32'h1C1C1C1C);
    @(negedge clk); chk(tx_k == 4'h8 && tx_data == 32'h7C005A3C, "R11 ack follows", tx_data, 32'h7C005A3C);
    @(negedge clk); chk(tx_k == 4'hF && tx_data == 32'hFCFCFCFC, "R9 ack end", tx_data, 32'hFCFCFCFC);

    // R5 R4 R9: three channels, ch2 wraps its region, ack requested mid-frame
    write_pkt(0, 0, 16, 1); write_pkt(1, 4, 9, 2); write_pkt(2, 28, 8, 3);
    post(0, 0, 16, 1);
    repeat (3) @(negedge clk);
    ack_req = 1; ack_info = 16'hBEEF;
    @(negedge clk); ack_req = 0;
    post(1, 4, 9, 1); post(2, 28, 8, 1);
    wait_frames(3);
    chk(frame_cnt == 3, "R5 three frames", 32'(frame_cnt), 3);
    chk(frame_ch[0] == 0 && frame_ch[1] == 1 && frame_ch[2] == 2, "R5 order 0,1,2",
        32'(frame_ch[0] * 100 + frame_ch[1] * 10 + frame_ch[2]), 32'd12);
    chk(ack_in_frame >= 1 && last_ack_info == 16'hBEEF, "R9 ack inside payload",
        32'(ack_in_frame), 1);

    // R6: post to a waiting channel is ignored (resend header keeps length 9)
    post(1, 0, 12, 0);
    repeat (40) @(negedge clk);
    chk(frame_cnt == 3, "R6 no resend while waiting", 32'(frame_cnt), 3);

    // R7 R5: nak ch1 while ch0 free; during its resend ch2 naked and ch0 reposted
    verdict(0, 0);
    write_pkt(0, 8, 10, 4);
    verdict(1, 1); verdict(2, 1); post(0, 8, 10, 1);
    wait_frames(6);
    chk(frame_ch[3] == 1, "R7 nak resends ch1", 32'(frame_ch[3]), 1);
    chk(frame_ch[4] == 2 && frame_ch[5] == 0, "R5 round robin after ch1 picks ch2",
        32'(frame_ch[4] * 10 + frame_ch[5]), 32'd20);
    verdict(0, 0); verdict(1, 0); verdict(2, 0);
    repeat (100) @(negedge clk);
    chk(frame_cnt == 6, "R6 positive acks free all", 32'(frame_cnt), 6);

    // R8: no verdict for ch2, resend after timeout
    write_pkt(2, 10, 8, 5);
    post(2, 10, 8, 1);
    base = frame_cnt;
    wait_frames(base + 2);
    gap = frame_sop[base + 1] - frame_eop[base];
    chk(frame_cnt == base + 2 && frame_ch[base + 1] == 2, "R8 timeout resend", 32'(frame_cnt), 32'(base + 2));
    chk(gap == TMO + 1 || gap == TMO + 3, "R8 timeout spacing", 32'(gap), 32'(TMO + 1));
    verdict(2, 0);

    // sweep of lengths and start offsets across all channels
    for (int L = 8; L <= 20; L++) begin
      base = frame_cnt;
      for (int c = 0; c < NCH; c++) write_pkt(c, (L * 5 + c * 11) % DEPTH, L + c, L * 7 + c);
      for (int c = 0; c < NCH; c++) post(c, (L * 5 + c * 11) % DEPTH, L + c, 1);
      if (L % 3 == 0) begin @(negedge clk); ack_req = 1; ack_info = 16'(L); @(negedge clk); ack_req = 0; end
      wait_frames(base + 3);
      chk(frame_cnt == base + 3 && frame_ch[base] == 0 && frame_ch[base + 1] == 1 && frame_ch[base + 2] == 2,
          "R5 sweep order", 32'(frame_cnt), 32'(base + 3));
      for (int c = 0; c < NCH; c++) verdict(c, 0);
    end
    repeat (60) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule